// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block scans a 1/8-duty multiplexed LCD panel. It keeps a display memory of 8 rows by 64 bits and gives each row a fixed number of clocks, the row time. During a row's time it selects one common line and drives every segment line from that row's bits. Each common output and each segment output is a 2-bit code, and an analog stage outside the block turns that code into one of four drive voltages. The drive polarity swaps at the end of every frame. A one-clock frame sync pulse marks the start of each frame, so that several such blocks can be kept in step.

Two asynchronous control inputs gate the display. The power-on-reset input forces a static dark pattern on every output. The blank input darkens only the segments while the commons keep scanning. When either input is released, the scan restarts from row 0 with a sync pulse. Segment data then appears one row time later, beginning with row 1. A plain parallel port writes whole rows into the memory at any time, including while the display is blanked or held in reset.

Top module: `lcd_mux_seq`

## Requirements
- R1: While the synchronised power-on-reset is high (and after `rst`), every common code is 3, every segment code is 2 and `frame_sync` is 0. The scan holds at row 0.
- R2: `por_in` and `blank_in` each pass through two flops. When `por_in` is sampled low at clock edge k after being high, `frame_sync` is 1 after edge k+1, for one clock.
- R3: A restart sets the scan to row 0 and selects common 0 for the next `ROW_CLKS` clocks. Every segment shows its off level during that first row time.
- R4: One row time after a restart, row 1 is shown. After that, row r is shown while common r is selected, and each row lasts `ROW_CLKS` clocks. Segment i takes bit i of the row word.
- R5: The codes are 0=GND, 1=VDSP, 2=V1 for commons and V3 for segments, 3=V4 for commons and V2 for segments. In frame A: selected common=1, other commons=3, segment with bit 1 = 0, segment with bit 0 = 3. In frame B: selected common=0, other commons=2, segment with bit 1 = 1, segment with bit 0 = 2. Common i and segment i use bits [2i+1:2i].
- R6: Release of power-on-reset starts in frame B. At each wrap from row 7 to row 0 the polarity flips and `frame_sync` pulses for one clock.
- R7: While blank is high and reset is low, every segment is at the off level of the current polarity, and the commons keep scanning.
- R8: Release of blank restarts the scan (sync pulse, row 0) and keeps the current polarity.
- R9: Writes on `wr_en` store `wr_data` into row `wr_row` whether or not the display is blanked or held in reset.
- R10: A row is loaded into the output latch at the row boundary. A write to that same row on the loading edge yields the old data.
- R11: A fall of blank while power-on-reset is high causes no sync pulse and leaves the static pattern unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_in | input | 1 | Asynchronous power-on-reset, high = static off |
| blank_in | input | 1 | Asynchronous blank, high = segments dark |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | ROW_W (3) | Row address of the write |
| wr_data | input | COLS (64) | Row word to store |
| frame_sync | output | 1 | One-clock frame start pulse |
| com_lvl | output | 2*ROWS (16) | Common level codes, 2 bits per common |
| seg_lvl | output | 2*COLS (128) | Segment level codes, 2 bits per segment |

## Verification
After a release input is sampled low at edge k, the sync pulse and the return of common 0 are due after edge k+1. Row 1 data is due `ROW_CLKS` edges after that. A latch load takes effect just after the boundary edge. A behavioural model in the bench steps on each rising edge, counting the same two synchroniser stages, the row tick counter and the latch. Every output is compared against this model on the falling edge. Directed checks count edges from a drive made on a falling edge and sample exactly at those points.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        LV_GND     = 2'd0,
        LV_VDSP    = 2'd1,
        LV_NSEL_LO = 2'd2,
        LV_NSEL_HI = 2'd3
    } lvl_e;

    typedef enum logic {
        POL_A = 1'b0,
        POL_B = 1'b1
    } pol_e;

    typedef struct packed {
        logic hold;
        logic blank;
        pol_e pol;
    } drive_ctl_t;

    function automatic lvl_e com_level(input logic sel, input pol_e pol);
        if (sel) return (pol == POL_A) ? LV_VDSP : LV_GND;
        return (pol == POL_A) ? LV_NSEL_HI : LV_NSEL_LO;
    endfunction

    function automatic lvl_e seg_level(input logic on, input pol_e pol);
        if (on) return (pol == POL_A) ? LV_GND : LV_VDSP;
        return (pol == POL_A) ? LV_NSEL_HI : LV_NSEL_LO;
    endfunction

endpackage

// File: rtl/lcd_in_sync.sv
module lcd_in_sync (
    input  logic clk,
    input  logic rst,
    input  logic por_in,
    input  logic blank_in,
    output logic por_s,
    output logic blank_s,
    output logic restart,
    output logic por_restart
);
    logic [1:0] por_q;
    logic [1:0] blk_q;
    logic       blank_restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            por_q <= 2'b11;
            blk_q <= 2'b11;
        end else begin
            por_q <= {por_q[0], por_in};
            blk_q <= {blk_q[0], blank_in};
        end
    end

    assign por_s         = por_q[1];
    assign blank_s       = blk_q[1];
    assign por_restart   = por_q[1] & ~por_q[0];
    // blank release only counts when reset is also released
    assign blank_restart = blk_q[1] & ~blk_q[0] & ~por_q[0];
    assign restart       = por_restart | blank_restart;

    AST_POR_FALL_RESTART: assert property (@(posedge clk) disable iff (rst)
        $fell(por_in) |=> por_restart); // R2

endmodule

// File: rtl/lcd_row_timer.sv
module lcd_row_timer
    import lcd_seq_pkg::*;
#(
    parameter int ROWS     = 8,
    parameter int ROW_CLKS = 16,
    localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int TICK_W  = (ROW_CLKS > 1) ? $clog2(ROW_CLKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             restart,
    input  logic             por_restart,
    output logic [ROW_W-1:0] row,
    output pol_e             pol,
    output logic             frame_sync,
    output logic             load,
    output logic [ROW_W-1:0] load_row
);
    logic [TICK_W-1:0] tick;
    logic              last_tick;
    logic              last_row;

    assign last_tick = (tick == TICK_W'(ROW_CLKS - 1));
    assign last_row  = (row == ROW_W'(ROWS - 1));
    assign load      = !restart && !hold && last_tick;
    assign load_row  = last_row ? '0 : row + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick       <= '0;
            row        <= '0;
            pol        <= POL_A;
            frame_sync <= 1'b0;
        end else begin
            frame_sync <= 1'b0;
            if (restart) begin
                tick       <= '0;
                row        <= '0;
                frame_sync <= 1'b1;
                if (por_restart) pol <= POL_B;
            end else if (hold) begin
                tick <= '0;
                row  <= '0;
            end else if (last_tick) begin
                tick <= '0;
                row  <= load_row;
                if (last_row) begin
                    pol        <= pol_e'(~pol);
                    frame_sync <= 1'b1;
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && !restart) |=> !frame_sync); // R6
    AST_RESTART_ROW0: assert property (@(posedge clk) disable iff (rst)
        restart |=> (row == '0 && frame_sync)); // R3
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        (hold && !restart) |=> (row == '0 && !frame_sync)); // R1
    AST_WRAP_FLIP: assert property (@(posedge clk) disable iff (rst)
        (load && last_row) |=> (pol != $past(pol) && frame_sync)); // R6
    AST_POR_STARTS_B: assert property (@(posedge clk) disable iff (rst)
        por_restart |=> pol == POL_B); // R6

endmodule

// File: rtl/lcd_seg_ram.sv
module lcd_seg_ram #(
    parameter int ROWS   = 8,
    parameter int COLS   = 64,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COLS-1:0]  wr_data,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] rd_row,
    input  logic             clr,
    output logic [COLS-1:0]  row_bits
);
    logic [COLS-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_row] <= wr_data;
    end

    // read sees the pre-edge contents, so a same-edge write is not visible
    always_ff @(posedge clk) begin
        if (rst || clr) row_bits <= '0;
        else if (rd_en) row_bits <= mem[rd_row];
    end

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> row_bits == '0); // R3
    AST_NO_LOAD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !clr) |=> $stable(row_bits)); // R7

endmodule

// File: rtl/lcd_drive_map.sv
module lcd_drive_map
    import lcd_seq_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int COLS   = 64,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  drive_ctl_t         ctl,
    input  logic [ROW_W-1:0]   row,
    input  logic [COLS-1:0]    row_bits,
    output logic [2*ROWS-1:0]  com_lvl,
    output logic [2*COLS-1:0]  seg_lvl
);
    for (genvar gi = 0; gi < ROWS; gi++) begin : g_com
        assign com_lvl[2*gi +: 2] = ctl.hold ? LV_NSEL_HI
                                  : com_level(row == ROW_W'(gi), ctl.pol);
    end

    for (genvar gs = 0; gs < COLS; gs++) begin : g_seg
        assign seg_lvl[2*gs +: 2] = ctl.hold ? LV_NSEL_LO
                                  : seg_level(row_bits[gs] & ~ctl.blank, ctl.pol);
    end

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
    import lcd_seq_pkg::*;
#(
    parameter int ROWS     = 8,
    parameter int COLS     = 64,
    parameter int ROW_CLKS = 16,
    localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               por_in,
    input  logic               blank_in,
    input  logic               wr_en,
    input  logic [ROW_W-1:0]   wr_row,
    input  logic [COLS-1:0]    wr_data,
    output logic               frame_sync,
    output logic [2*ROWS-1:0]  com_lvl,
    output logic [2*COLS-1:0]  seg_lvl
);
    logic             por_s, blank_s, restart, por_restart;
    logic [ROW_W-1:0] row, load_row;
    pol_e             pol;
    logic             load;
    logic [COLS-1:0]  row_bits;
    drive_ctl_t       ctl;

    lcd_in_sync u_sync (
        .clk(clk), .rst(rst), .por_in(por_in), .blank_in(blank_in),
        .por_s(por_s), .blank_s(blank_s),
        .restart(restart), .por_restart(por_restart)
    );

    lcd_row_timer #(.ROWS(ROWS), .ROW_CLKS(ROW_CLKS)) u_timer (
        .clk(clk), .rst(rst), .hold(por_s), .restart(restart),
        .por_restart(por_restart), .row(row), .pol(pol),
        .frame_sync(frame_sync), .load(load), .load_row(load_row)
    );

    lcd_seg_ram #(.ROWS(ROWS), .COLS(COLS)) u_ram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row),
        .wr_data(wr_data), .rd_en(load & ~blank_s), .rd_row(load_row),
        .clr(restart), .row_bits(row_bits)
    );

    assign ctl = '{hold: por_s, blank: blank_s, pol: pol};

    lcd_drive_map #(.ROWS(ROWS), .COLS(COLS)) u_map (
        .ctl(ctl), .row(row), .row_bits(row_bits),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

endmodule

// File: tb/sim_lcd_mux_seq.sv
`timescale 1ns/1ps
module sim_lcd_mux_seq;
    localparam int ROWS = 8;
    localparam int COLS = 64;
    localparam int RC   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_in = 1'b1;
    logic        blank_in = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_row = '0;
    logic [63:0] wr_data = '0;
    wire         frame_sync;
    wire [15:0]  com_lvl;
    wire [127:0] seg_lvl;

    always #2.5 clk = ~clk;

    lcd_mux_seq #(.ROWS(ROWS), .COLS(COLS), .ROW_CLKS(RC)) u0 (
        .clk(clk), .rst(rst), .por_in(por_in), .blank_in(blank_in),
        .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .frame_sync(frame_sync), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // behavioural reference state
    int m_p1, m_p2, m_b1, m_b2, m_tick, m_row, m_pol, m_fs;
    logic [63:0] m_latch;
    logic [63:0] m_mem [8];

    function automatic logic [63:0] patt(int r);
        return {8{8'(8'hA5 ^ (r * 29))}} ^ (64'h1 << (r * 7));
    endfunction

    function automatic logic [1:0] off_code(int pol);
        return (pol != 0) ? 2'd2 : 2'd3;
    endfunction

    function automatic logic [127:0] seg_exp(logic [63:0] bits, int pol, int blk);
        logic [127:0] v;
        for (int i = 0; i < 64; i++)
            v[2*i +: 2] = (bits[i] && blk == 0) ? ((pol != 0) ? 2'd1 : 2'd0) : off_code(pol);
        return v;
    endfunction

    function automatic logic [15:0] com_exp(int row, int pol);
        logic [15:0] v;
        for (int i = 0; i < 8; i++)
            v[2*i +: 2] = (i == row) ? ((pol != 0) ? 2'd0 : 2'd1) : off_code(pol);
        return v;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int pf, bf;
        cyc++;
        if (rst) begin
            m_p1 = 1; m_p2 = 1; m_b1 = 1; m_b2 = 1;
            m_tick = 0; m_row = 0; m_pol = 0; m_fs = 0; m_latch = '0;
        end else begin
            pf = (m_p2 == 1 && m_p1 == 0) ? 1 : 0;
            bf = (m_b2 == 1 && m_b1 == 0 && m_p1 == 0) ? 1 : 0;
            m_fs = 0;
            if (pf == 1 || bf == 1) begin
                m_tick = 0; m_row = 0; m_fs = 1; m_latch = '0;
                if (pf == 1) m_pol = 1;
            end else if (m_p2 == 1) begin
                m_tick = 0; m_row = 0;
            end else if (m_tick == RC - 1) begin
                m_tick = 0;
                if (m_b2 == 0) m_latch = m_mem[(m_row + 1) % ROWS];
                if (m_row == ROWS - 1) begin
                    m_row = 0; m_pol = 1 - m_pol; m_fs = 1;
                end else m_row = m_row + 1;
            end else m_tick = m_tick + 1;
            m_p2 = m_p1; m_p1 = por_in;
            m_b2 = m_b1; m_b1 = blank_in;
        end
        if (wr_en) m_mem[wr_row] = wr_data;
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R6 frame_sync", {127'b0, frame_sync}, {127'b0, (m_fs != 0)});
            if (m_p2 != 0) begin
                chk("R1 commons", {112'b0, com_lvl}, {112'b0, {8{2'd3}}});
                chk("R1 segments", seg_lvl, {64{2'd2}});
            end else begin
                chk("R5 commons", {112'b0, com_lvl}, {112'b0, com_exp(m_row, m_pol)});
                chk(m_b2 != 0 ? "R7 segments" : "R4 segments", seg_lvl,
                    seg_exp(m_latch, m_pol, m_b2));
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int keep_pol;
        logic [63:0] old;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset commons", {112'b0, com_lvl}, {112'b0, {8{2'd3}}});
        chk("R1 reset segments", seg_lvl, {64{2'd2}});
        chk("R1 reset sync", {127'b0, frame_sync}, 128'd0);

        // R9: load every row while held in reset and blank
        for (int r = 0; r < ROWS; r++) begin
            wr_en = 1'b1; wr_row = 3'(r); wr_data = patt(r);
            @(negedge clk);
        end
        wr_en = 1'b0;

        // R11: blank fall under reset has no effect
        blank_in = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R11 no sync", {127'b0, frame_sync}, 128'd0);
            chk("R11 static", seg_lvl, {64{2'd2}});
        end
        blank_in = 1'b1;
        repeat (3) @(negedge clk);

        // R2: reset release
        por_in = 1'b0;
        @(negedge clk);
        chk("R2 not yet", {127'b0, frame_sync}, 128'd0);
        @(negedge clk);
        chk("R2 sync pulse", {127'b0, frame_sync}, 128'd1);
        chk("R6 frame B", {126'b0, com_lvl[1:0]}, 128'd0);
        chk("R7 forced off", seg_lvl, {64{2'd2}});
        repeat (2 * ROWS * RC + 5) @(negedge clk);

        // R8 / R3 / R4: blank release
        keep_pol = m_pol;
        blank_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 sync pulse", {127'b0, frame_sync}, 128'd1);
        chk("R8 polarity kept", {126'b0, com_lvl[1:0]}, {126'b0, (keep_pol != 0) ? 2'd0 : 2'd1});
        chk("R3 first slot dark", seg_lvl, seg_exp(64'd0, keep_pol, 0));
        repeat (RC - 1) @(negedge clk);
        chk("R3 end of slot dark", seg_lvl, seg_exp(64'd0, keep_pol, 0));
        @(negedge clk);
        chk("R4 row 1 shown", seg_lvl, seg_exp(patt(1), keep_pol, 0));
        chk("R4 common 1", {112'b0, com_lvl}, {112'b0, com_exp(1, keep_pol)});
        repeat (ROWS * RC) @(negedge clk);

        // R10: write on the loading edge yields old data
        while (m_tick != RC - 1) @(negedge clk);
        wr_row = 3'((m_row + 1) % ROWS);
        old = m_mem[(m_row + 1) % ROWS];
        wr_data = ~old;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 old data", seg_lvl, seg_exp(old, m_pol, 0));
        repeat (2 * ROWS * RC) @(negedge clk);

        // R7: blank during scan
        blank_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 blank off", seg_lvl, seg_exp(64'd0, m_pol, 1));
        repeat (3 * RC) @(negedge clk);
        blank_in = 1'b0;
        repeat (ROWS * RC + 4) @(negedge clk);

        // R1: reset reasserted mid-scan
        por_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 static again", {112'b0, com_lvl}, {112'b0, {8{2'd3}}});
        repeat (10) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule